// File: doc/BRIEF.md
# Twisted-Ring Test Pattern Generator

This block produces built-in self-test stimulus without a linear feedback shift register. An n-bit input scan register is turned into a Johnson-style counter by feeding its serial input through a four-way source selector, one leg of which inverts the bit leaving the far end. A small parameter ROM holds seed words. Each seed is shifted in bit by bit, and the ring then steps through its twisted sequence before the next seed is loaded. Changing the seed gives a new family of patterns.

A shift-position counter of log2(n) bits picks which ROM bit enters during a load and advances the seed address when it wraps. A second counter spans the 2n ring steps applied per seed. The parallel register contents drive the circuit under test. The scan enable tells the surrounding scan logic when the register is shifting.

Two application styles are supported. In test-per-clock mode every ring step is a pattern and shifting never pauses. In scan mode each ring step is followed by one capture cycle with scan enable low. The raw reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `trc_pattern_gen`

## Requirements
- R1: After reset is released, pattern_o is all zeros and both scan_en_o and done_o are low.
- R2: A high start_i while idle or finished begins a seed load from seed index 0 on the next clock. A start_i during a load, run or capture has no effect on the outputs.
- R3: A seed load lasts exactly N clocks with scan_en_o high. Each clock shifts pattern_o one place toward the MSB and enters the next seed bit at bit 0, most significant seed bit first, so after the load pattern_o equals the seed word. Seeds are used in index order 0 to NUM_SEEDS-1.
- R4: With twist_en_i high, each run step makes pattern_o equal {previous[N-2:0], ~previous[N-1]}. Over the 2N steps of one seed the register shows 2N distinct values and then returns to the seed.
- R5: With twist_en_i low, each run step rotates pattern_o: {previous[N-2:0], previous[N-1]}.
- R6: Exactly 2N run steps are applied per seed. Then the next seed load starts, or the generator finishes after the last seed.
- R7: With scan_mode_i high, every run step is followed by exactly one capture cycle. In that cycle scan_en_o is low and pattern_o holds its value.
- R8: With scan_mode_i low, there are no capture cycles, and scan_en_o stays high from the first load clock to the last run step.
- R9: After the last run step (and its capture in scan mode), done_o rises and stays high with scan_en_o low and pattern_o frozen until the next start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| start_i | input | 1 | Begin a complete seed sequence when idle or finished |
| scan_mode_i | input | 1 | 1: scan style with a capture cycle per step; 0: test-per-clock |
| twist_en_i | input | 1 | 1: inverted feedback (twisted ring); 0: plain rotation |
| pattern_o | output | N | Parallel scan register contents applied to the circuit under test |
| scan_en_o | output | 1 | High while the register shifts |
| done_o | output | 1 | High once all seeds have been applied |

## Verification
The assertions assume that scan_mode_i and twist_en_i stay steady from a start until done_o rises, and that N is a power of two. The bench respects this by redrawing both mode inputs only while the generator is idle or finished. It forces the four mode combinations on the first four starts and fires start_i at random during busy phases to show it is ignored.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // Serial input source select (2-bit, 4-to-1 selector)
  typedef enum logic [1:0] {
    SRC_ROT   = 2'b00,  // recirculate far-end bit unchanged
    SRC_TWIST = 2'b01,  // inverted far-end bit
    SRC_SEED  = 2'b10,  // next ROM seed bit
    SRC_ZERO  = 2'b11   // constant zero
  } src_sel_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_CAPT = 3'd3,
    ST_FIN  = 3'd4
  } gen_state_t;

endpackage

// File: rtl/trc_seed_rom.sv
module trc_seed_rom #(
  parameter int N         = 8,
  parameter int NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS-1:0][N-1:0] SEEDS = '0,
  localparam int CNT_W  = $clog2(N),
  localparam int SEED_W = $clog2(NUM_SEEDS + 1)
) (
  input  logic [SEED_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  bit_i,
  output logic              bit_o
);

  always_comb begin
    bit_o = 1'b0;
    for (int s = 0; s < NUM_SEEDS; s++) begin
      if (addr_i == SEED_W'(s)) bit_o = SEEDS[s][bit_i];
    end
  end

endmodule

// File: rtl/trc_shift_reg.sv
module trc_shift_reg
  import trc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  src_sel_t     sel_i,
  input  logic         seed_bit_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] q_q, q_d;
  logic         sin;

  always_comb begin
    unique case (sel_i)
      SRC_ROT:   sin = q_q[N-1];
      SRC_TWIST: sin = ~q_q[N-1];
      SRC_SEED:  sin = seed_bit_i;
      default:   sin = 1'b0;
    endcase
    q_d = shift_en_i ? {q_q[N-2:0], sin} : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(q_q)); // R7
  AST_TWIST_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && sel_i == SRC_TWIST) |=> (q_q[0] == !$past(q_q[N-1]))); // R4
  AST_ROT_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && sel_i == SRC_ROT) |=> (q_q[0] == $past(q_q[N-1]))); // R5

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int N         = 8,
  parameter int NUM_SEEDS = 4,
  localparam int CNT_W  = $clog2(N),
  localparam int RUN_W  = $clog2(2 * N),
  localparam int SEED_W = $clog2(NUM_SEEDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              scan_mode_i,
  input  logic              twist_en_i,
  output logic              shift_en_o,
  output src_sel_t          sel_o,
  output logic [SEED_W-1:0] rom_addr_o,
  output logic [CNT_W-1:0]  rom_bit_o,
  output logic              scan_en_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(N - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(2 * N - 1);
  localparam logic [SEED_W-1:0] SEED_END  = SEED_W'(NUM_SEEDS);

  gen_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [SEED_W-1:0] seed_q, seed_d;
  gen_state_t        after_seed;

  always_comb begin
    after_seed = (seed_q == SEED_END) ? ST_FIN : ST_LOAD;
    st_d       = st_q;
    cnt_d      = cnt_q;
    run_d      = run_q;
    seed_d     = seed_q;
    shift_en_o = 1'b0;
    sel_o      = SRC_ZERO;
    scan_en_o  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_FIN: begin
        if (start_i) begin
          st_d   = ST_LOAD;
          cnt_d  = '0;
          seed_d = '0;
        end
      end
      ST_LOAD: begin
        shift_en_o = 1'b1;
        sel_o      = SRC_SEED;
        scan_en_o  = 1'b1;
        cnt_d      = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          st_d   = ST_RUN;
          seed_d = seed_q + 1'b1;
          run_d  = '0;
        end
      end
      ST_RUN: begin
        shift_en_o = 1'b1;
        sel_o      = twist_en_i ? SRC_TWIST : SRC_ROT;
        scan_en_o  = 1'b1;
        run_d      = run_q + 1'b1;
        if (scan_mode_i)           st_d = ST_CAPT;
        else if (run_q == RUN_LAST) st_d = after_seed;
      end
      ST_CAPT: begin
        st_d = (run_q == '0) ? after_seed : ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      run_q  <= '0;
      seed_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      seed_q <= seed_d;
    end
  end

  assign rom_addr_o = seed_q;
  assign rom_bit_o  = CNT_LAST - cnt_q;
  assign done_o     = (st_q == ST_FIN);

  AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && cnt_q == CNT_LAST) |=> (st_q == ST_RUN)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !scan_mode_i && run_q != RUN_LAST) |=> (st_q == ST_RUN)); // R2
  AST_ONE_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT) |=> (st_q != ST_CAPT)); // R7
  AST_NO_CAPT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !scan_mode_i) |=> (st_q != ST_CAPT)); // R8
  AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN && !start_i) |=> (st_q == ST_FIN)); // R9
  AST_SEED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |-> (seed_q < SEED_END)); // R6

endmodule

// File: rtl/trc_pattern_gen.sv
module trc_pattern_gen
  import trc_pkg::*;
#(
  parameter int N         = 8,
  parameter int NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS-1:0][N-1:0] SEEDS = {8'hA5, 8'h3C, 8'h01, 8'hF0},
  localparam int CNT_W  = $clog2(N),
  localparam int SEED_W = $clog2(NUM_SEEDS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         scan_mode_i,
  input  logic         twist_en_i,
  output logic [N-1:0] pattern_o,
  output logic         scan_en_o,
  output logic         done_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic              shift_en;
  src_sel_t          sel;
  logic [SEED_W-1:0] rom_addr;
  logic [CNT_W-1:0]  rom_bit;
  logic              seed_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  trc_ctrl #(.N(N), .NUM_SEEDS(NUM_SEEDS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .scan_mode_i (scan_mode_i),
    .twist_en_i  (twist_en_i),
    .shift_en_o  (shift_en),
    .sel_o       (sel),
    .rom_addr_o  (rom_addr),
    .rom_bit_o   (rom_bit),
    .scan_en_o   (scan_en_o),
    .done_o      (done_o)
  );

  trc_seed_rom #(.N(N), .NUM_SEEDS(NUM_SEEDS), .SEEDS(SEEDS)) rom_i (
    .addr_i (rom_addr),
    .bit_i  (rom_bit),
    .bit_o  (seed_bit)
  );

  trc_shift_reg #(.N(N)) sreg_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .shift_en_i (shift_en),
    .sel_i      (sel),
    .seed_bit_i (seed_bit),
    .q_o        (pattern_o)
  );

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> (!done_o || $stable(pattern_o))); // R9

endmodule

// File: tb/trc_pattern_gen_tb.sv
module trc_pattern_gen_tb_top;

  localparam int N  = 8;
  localparam int NS = 4;
  localparam logic [NS-1:0][N-1:0] TB_SEEDS = {8'hA5, 8'h3C, 8'h01, 8'hF0};

  localparam int M_IDLE = 0, M_LOAD = 1, M_RUN = 2, M_CAPT = 3, M_FIN = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, scan_mode, twist;
  logic [N-1:0] pattern;
  logic         scan_en, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int           m_state, m_cnt, m_run, m_seed, n_starts;
  logic [N-1:0] m_pat;
  bit           m_scan, m_twist, pend_eval;
  logic [N-1:0] hist [2*N];

  always #2 clk = ~clk;

  trc_pattern_gen #(.N(N), .NUM_SEEDS(NS), .SEEDS(TB_SEEDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scan_mode_i(scan_mode),
    .twist_en_i(twist), .pattern_o(pattern), .scan_en_o(scan_en), .done_o(done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string pat_req(int st, bit tw);
    case (st)
      M_LOAD:  return "R3";
      M_RUN:   return tw ? "R4" : "R5";
      M_CAPT:  return "R7";
      M_FIN:   return "R9";
      default: return "R2";
    endcase
  endfunction

  function automatic int count_distinct();
    int c = 0;
    for (int i = 0; i < 2*N; i++) begin
      bit dup = 1'b0;
      for (int j = 0; j < i; j++) if (hist[j] == hist[i]) dup = 1'b1;
      if (!dup) c++;
    end
    return c;
  endfunction

  task automatic model_step();
    case (m_state)
      M_IDLE, M_FIN: if (start) begin
        m_state = M_LOAD; m_cnt = 0; m_seed = 0;
        m_scan = scan_mode; m_twist = twist;
      end
      M_LOAD: begin
        m_pat = {m_pat[N-2:0], TB_SEEDS[m_seed][N-1-m_cnt]};
        if (m_cnt == N-1) begin
          m_state = M_RUN; m_seed++; m_run = 0; m_cnt = 0;
        end else m_cnt++;
      end
      M_RUN: begin
        m_pat = {m_pat[N-2:0], m_twist ? ~m_pat[N-1] : m_pat[N-1]};
        m_run++;
        if (m_scan) m_state = M_CAPT;
        else if (m_run == 2*N) begin
          m_state = (m_seed == NS) ? M_FIN : M_LOAD; pend_eval = m_twist;
        end
      end
      M_CAPT: begin
        if (m_run == 2*N) begin
          m_state = (m_seed == NS) ? M_FIN : M_LOAD; pend_eval = m_twist;
        end else m_state = M_RUN;
      end
      default: m_state = M_IDLE;
    endcase
  endtask

  task automatic compare_outputs();
    bit exp_se = (m_state == M_LOAD || m_state == M_RUN);
    check(pattern == m_pat, pat_req(m_state, m_twist), "pattern", int'(pattern), int'(m_pat));
    check(scan_en == exp_se, m_scan ? "R7" : "R8", "scan_en", int'(scan_en), int'(exp_se));
    check(done == (m_state == M_FIN), "R9", "done", int'(done), int'(m_state == M_FIN));
    if (m_state == M_RUN && m_twist) hist[m_run] = pattern;
    if (pend_eval) begin
      pend_eval = 1'b0;
      // R4 / R6: 2N run steps visit 2N distinct states and come back to the seed
      check(count_distinct() == 2*N, "R4", "distinct states", count_distinct(), 2*N);
      check(pattern == hist[0], "R6", "return to seed", int'(pattern), int'(hist[0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; scan_mode = 1'b0; twist = 1'b1;
    m_state = M_IDLE; m_cnt = 0; m_run = 0; m_seed = 0; m_pat = '0;
    m_scan = 1'b0; m_twist = 1'b1; pend_eval = 1'b0; n_starts = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(pattern == '0, "R1", "reset pattern", int'(pattern), 0);
    check(scan_en == 1'b0, "R1", "reset scan_en", int'(scan_en), 0);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      compare_outputs();
      if (m_state == M_IDLE || m_state == M_FIN) begin
        start = ($urandom_range(3) == 0);
        if (start) begin
          if (n_starts < 4) begin
            scan_mode = n_starts[0]; twist = ~n_starts[1];
          end else begin
            scan_mode = $urandom_range(1); twist = $urandom_range(1);
          end
          n_starts++;
        end
      end else begin
        start = ($urandom_range(7) == 0);  // R2: ignored while busy
      end
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    compare_outputs();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule